// File: doc/BRIEF.md
# PCM Channel Power and Clock-Mode Controller

This block sits beside the serial PCM port of a voice codec channel and decides three things: whether the channel is powered, which master clock and which bit clock the receive side runs from, and how the master clock is divided down to the 256 kHz internal rate. It needs no configuration writes. Two dual-purpose pins are watched instead. The receive master clock / power-down pin and the receive bit clock / clock-select pin are each classed as static low, static high or toggling, and the class decides what the pin means.

The channel wakes on the first frame-sync rising edge in either direction. It sleeps when the power-down pin is held high, or when no frame sync has arrived for a timeout window. The transmit data output is enabled only from the second transmit frame sync after wake-up, so the first slot never carries a stale code. A divider turns transmit master clock edges into a sub-frame tick and a frame-start pulse. In the 1.544 MHz mode it swallows one master clock edge in every frame of 193, which gives the same 32 ticks per frame as the other rates.

All pins are asynchronous to the system clock and are synchronised inside the block. A pin is taken to be static once `STATIC_CYC` system clocks pass with no edge on it.

Top module: `pcm_pwr_clk_ctrl`

## Requirements
- R1: After reset `pwr_up_o`, `tx_out_en_o`, `rx_mclk_own_o`, `rx_bclk_own_o`, `sub_tick_o` and `frame_start_o` are 0, and `div_mode_o` is 0.
- R2: While the power-down pin is classed static high, the block is powered down within two cycles and frame-sync edges do not wake it.
- R3: When powered, the block powers down exactly `TIMEOUT_CYC` system cycles after the last detected frame-sync rising edge, unless another edge arrives first.
- R4: When powered down and the power-down pin is not static high, a rising edge on either frame sync powers the block up.
- R5: `tx_out_en_o` goes to 1 only from the second transmit frame-sync rising edge counted since wake-up, and it returns to 0 whenever the block powers down.
- R6: `rx_mclk_own_o` is 1 while the power-down pin toggles, which means the receive side uses its own master clock. It is 0 while that pin is static, so the transmit master clock drives all timing.
- R7: While the clock-select pin is static, `rx_bclk_own_o` is 0 and `div_mode_o` follows the pin level: level 0 gives code 0 (2.048 MHz), and level 1 gives code 1 (1.536 MHz) or code 2 (1.544 MHz) when `sel_193_i` is 1. While the pin toggles, `rx_bclk_own_o` is 1 and the mode comes from the `DEFAULT_NARROW` parameter (0 gives code 0).
- R8: While powered, `frame_start_o` pulses once every 256, 192 or 193 transmit master clock rising edges for codes 0, 1 and 2. `sub_tick_o` pulses 32 times per frame and coincides with each frame start. In code 2 the 193rd edge produces no tick.
- R9: A pin is classed toggling for at least 4 system cycles after its last change. It is classed static no later than `STATIC_CYC`+6 cycles after that change.
- R10: A frame-sync rising edge detected in the same cycle that the timeout expires keeps the block powered, and it does not restart the transmit gating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, puts the channel in powered-down state |
| mclkx_i | input | 1 | Transmit master clock (asynchronous) |
| mclkr_pd_i | input | 1 | Receive master clock, or power-down level when static |
| bclkr_sel_i | input | 1 | Receive bit clock, or divider select level when static |
| fsx_i | input | 1 | Transmit frame sync |
| fsr_i | input | 1 | Receive frame sync |
| sel_193_i | input | 1 | Chooses 1.544 MHz over 1.536 MHz for the narrow divider |
| pwr_up_o | output | 1 | Channel powered |
| tx_out_en_o | output | 1 | Transmit data output driver enable |
| rx_mclk_own_o | output | 1 | Receive side uses its own master clock |
| rx_bclk_own_o | output | 1 | Receive side uses its own bit clock |
| div_mode_o | output | 2 | Divider mode: 0 = 2.048, 1 = 1.536, 2 = 1.544 MHz |
| sub_tick_o | output | 1 | One-cycle pulse at the 256 kHz internal rate |
| frame_start_o | output | 1 | One-cycle pulse at each 8 kHz frame start |

## Verification
The timeout expiry and a new frame-sync edge can land in the same cycle, and the wake-versus-timeout decision must favour the edge. The bench provokes this by sweeping the spacing between transmit frame syncs from two cycles below the timeout to two above it. After each step it reads `tx_out_en_o`, which stays high only if the channel never dropped, so the boundary spacing equal to the timeout must keep it high and every larger spacing must clear it. A second overlap, a power-down level on the pin together with frame-sync activity, is judged by checking that the channel stays asleep.

// File: rtl/pcm_pc_pkg.sv
package pcm_pc_pkg;

    typedef enum logic [1:0] {
        PIN_LOW    = 2'd0,
        PIN_HIGH   = 2'd1,
        PIN_TOGGLE = 2'd2
    } pin_cls_e;

    typedef enum logic [1:0] {
        DIV_2048 = 2'd0,
        DIV_1536 = 2'd1,
        DIV_1544 = 2'd2
    } div_mode_e;

    typedef enum logic {
        PW_DOWN = 1'b0,
        PW_UP   = 1'b1
    } pwr_st_e;

    // master clock edges per sub-frame tick
    localparam int RATIO_WIDE   = 8;
    localparam int RATIO_NARROW = 6;
    // master clock edges per frame (narrow frame without the absorbed edge)
    localparam int FRAME_WIDE   = 256;
    localparam int FRAME_NARROW = 192;

endpackage

// File: rtl/pcm_pc_sync_edge.sv
module pcm_pc_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic level_o,
    output logic edge_o
);
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign level_o = sh_q[STAGES-1];
    assign edge_o  = sh_q[STAGES-1] ^ sh_q[STAGES];
endmodule

// File: rtl/pcm_pc_pin_class.sv
module pcm_pc_pin_class
    import pcm_pc_pkg::*;
#(
    parameter int STATIC_CYC = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pin_i,
    output pin_cls_e cls_o
);
    localparam int CW = $clog2(STATIC_CYC + 1);
    localparam logic [CW-1:0] CNT_SAT = CW'(STATIC_CYC);

    typedef struct packed {
        logic [CW-1:0] quiet;
    } cls_st_t;

    cls_st_t st_d, st_q;
    logic    lvl, edg;

    pcm_pc_sync_edge #(.STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_i     (pin_i),
        .level_o (lvl),
        .edge_o  (edg)
    );

    always_comb begin
        st_d = st_q;
        if (edg)                    st_d.quiet = '0;
        else if (st_q.quiet != CNT_SAT) st_d.quiet = st_q.quiet + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.quiet <= CNT_SAT;
        else        st_q       <= st_d;
    end

    always_comb begin
        if (st_q.quiet != CNT_SAT) cls_o = PIN_TOGGLE;
        else if (lvl)              cls_o = PIN_HIGH;
        else                       cls_o = PIN_LOW;
    end
endmodule

// File: rtl/pcm_pc_power_fsm.sv
module pcm_pc_power_fsm
    import pcm_pc_pkg::*;
#(
    parameter int TIMEOUT_CYC = 8000,
    localparam int IW = $clog2(TIMEOUT_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pd_high_i,
    input  logic          fsx_rise_i,
    input  logic          fsr_rise_i,
    output logic          pwr_up_o,
    output logic          tx_en_o,
    output logic [IW-1:0] idle_o
);
    localparam logic [IW-1:0] IDLE_LAST = IW'(TIMEOUT_CYC - 1);

    typedef struct packed {
        pwr_st_e       st;
        logic [1:0]    fsx_seen;
        logic          tx_en;
        logic [IW-1:0] idle;
    } pwr_t;

    pwr_t s_d, s_q;
    logic any_rise;

    assign any_rise = fsx_rise_i | fsr_rise_i;

    always_comb begin
        s_d = s_q;
        if (pd_high_i) begin
            s_d = '0;
        end else if (s_q.st == PW_DOWN) begin
            if (any_rise) begin
                s_d.st       = PW_UP;
                s_d.idle     = '0;
                s_d.fsx_seen = fsx_rise_i ? 2'd1 : 2'd0;
            end
        end else begin
            if (any_rise) begin
                s_d.idle = '0;
                if (fsx_rise_i && s_q.fsx_seen != 2'd2)
                    s_d.fsx_seen = s_q.fsx_seen + 2'd1;
            end else if (s_q.idle == IDLE_LAST) begin
                s_d = '0;
            end else begin
                s_d.idle = s_q.idle + 1'b1;
            end
        end
        s_d.tx_en = (s_d.st == PW_UP) && (s_d.fsx_seen == 2'd2);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pwr_up_o = (s_q.st == PW_UP);
    assign tx_en_o  = s_q.tx_en;
    assign idle_o   = s_q.idle;
endmodule

// File: rtl/pcm_pc_frame_div.sv
module pcm_pc_frame_div
    import pcm_pc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run_i,
    input  logic      mclk_rise_i,
    input  div_mode_e mode_i,
    output logic      sub_tick_o,
    output logic      frame_start_o
);
    localparam int FIW = $clog2(FRAME_WIDE);
    localparam int SW  = $clog2(RATIO_WIDE);
    localparam logic [FIW-1:0] LAST_WIDE   = FIW'(FRAME_WIDE - 1);
    localparam logic [FIW-1:0] LAST_NARROW = FIW'(FRAME_NARROW - 1);
    localparam logic [FIW-1:0] SWALLOW_IDX = FIW'(FRAME_NARROW);
    localparam logic [SW-1:0]  RLAST_WIDE  = SW'(RATIO_WIDE - 1);
    localparam logic [SW-1:0]  RLAST_NAR   = SW'(RATIO_NARROW - 1);

    typedef struct packed {
        div_mode_e      mode;
        logic [FIW-1:0] idx;
        logic [SW-1:0]  sub;
        logic           tick;
        logic           fstart;
    } div_t;

    div_t d_d, d_q;
    logic [FIW-1:0] frame_last;
    logic [SW-1:0]  ratio_last;
    logic           swallow;

    always_comb begin
        case (d_q.mode)
            DIV_1536: frame_last = LAST_NARROW;
            DIV_1544: frame_last = SWALLOW_IDX;
            default:  frame_last = LAST_WIDE;
        endcase
        ratio_last = (d_q.mode == DIV_2048) ? RLAST_WIDE : RLAST_NAR;
        swallow    = (d_q.mode == DIV_1544) && (d_q.idx == SWALLOW_IDX);
    end

    always_comb begin
        d_d        = d_q;
        d_d.mode   = mode_i;
        d_d.tick   = 1'b0;
        d_d.fstart = 1'b0;
        if (!run_i || mode_i != d_q.mode) begin
            d_d.idx = '0;
            d_d.sub = '0;
        end else if (mclk_rise_i) begin
            if (!swallow) begin
                d_d.tick   = (d_q.sub == '0);
                d_d.fstart = (d_q.idx == '0);
                d_d.sub    = (d_q.sub == ratio_last) ? '0 : d_q.sub + 1'b1;
            end
            d_d.idx = (d_q.idx == frame_last) ? '0 : d_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_q <= '{mode: DIV_2048, idx: '0, sub: '0, tick: 1'b0, fstart: 1'b0};
        else        d_q <= d_d;
    end

    assign sub_tick_o    = d_q.tick;
    assign frame_start_o = d_q.fstart;
endmodule

// File: rtl/pcm_pwr_clk_ctrl.sv
module pcm_pwr_clk_ctrl
    import pcm_pc_pkg::*;
#(
    parameter int STATIC_CYC     = 64,
    parameter int TIMEOUT_CYC    = 100000,
    parameter bit DEFAULT_NARROW = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mclkx_i,
    input  logic       mclkr_pd_i,
    input  logic       bclkr_sel_i,
    input  logic       fsx_i,
    input  logic       fsr_i,
    input  logic       sel_193_i,
    output logic       pwr_up_o,
    output logic       tx_out_en_o,
    output logic       rx_mclk_own_o,
    output logic       rx_bclk_own_o,
    output logic [1:0] div_mode_o,
    output logic       sub_tick_o,
    output logic       frame_start_o
);
    localparam int N_DUAL = 2;   // index 0: power-down pin, 1: clock-select pin
    localparam int N_EDGE = 3;   // index 0: fsx, 1: fsr, 2: mclkx
    localparam int IW     = $clog2(TIMEOUT_CYC + 1);

    typedef struct packed {
        logic      mclk_own;
        logic      bclk_own;
        div_mode_e mode;
    } sel_t;

    logic [N_DUAL-1:0] dual_pin;
    pin_cls_e          dual_cls [N_DUAL];
    logic [N_EDGE-1:0] edge_pin, edge_lvl, edge_chg, edge_rise;

    pin_cls_e      pd_cls, bclk_cls;
    logic          fs_any_rise;
    logic [IW-1:0] fsm_idle;
    sel_t          sel_d, sel_q;
    div_mode_e     narrow_mode;

    assign dual_pin = {bclkr_sel_i, mclkr_pd_i};
    assign edge_pin = {mclkx_i, fsr_i, fsx_i};

    for (genvar g = 0; g < N_DUAL; g++) begin : g_cls
        pcm_pc_pin_class #(.STATIC_CYC(STATIC_CYC)) u_cls (
            .clk   (clk),
            .rst_n (rst_n),
            .pin_i (dual_pin[g]),
            .cls_o (dual_cls[g])
        );
    end

    for (genvar e = 0; e < N_EDGE; e++) begin : g_edge
        pcm_pc_sync_edge #(.STAGES(2)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .d_i     (edge_pin[e]),
            .level_o (edge_lvl[e]),
            .edge_o  (edge_chg[e])
        );
    end

    assign edge_rise   = edge_lvl & edge_chg;
    assign pd_cls      = dual_cls[0];
    assign bclk_cls    = dual_cls[1];
    assign fs_any_rise = edge_rise[0] | edge_rise[1];

    always_comb begin
        narrow_mode    = sel_193_i ? DIV_1544 : DIV_1536;
        sel_d          = sel_q;
        sel_d.mclk_own = (pd_cls == PIN_TOGGLE);
        sel_d.bclk_own = (bclk_cls == PIN_TOGGLE);
        case (bclk_cls)
            PIN_HIGH:   sel_d.mode = narrow_mode;
            PIN_TOGGLE: sel_d.mode = DEFAULT_NARROW ? narrow_mode : DIV_2048;
            default:    sel_d.mode = DIV_2048;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= '{mclk_own: 1'b0, bclk_own: 1'b0, mode: DIV_2048};
        else        sel_q <= sel_d;
    end

    pcm_pc_power_fsm #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_pwr (
        .clk        (clk),
        .rst_n      (rst_n),
        .pd_high_i  (pd_cls == PIN_HIGH),
        .fsx_rise_i (edge_rise[0]),
        .fsr_rise_i (edge_rise[1]),
        .pwr_up_o   (pwr_up_o),
        .tx_en_o    (tx_out_en_o),
        .idle_o     (fsm_idle)
    );

    pcm_pc_frame_div u_div (
        .clk           (clk),
        .rst_n         (rst_n),
        .run_i         (pwr_up_o),
        .mclk_rise_i   (edge_rise[2]),
        .mode_i        (sel_q.mode),
        .sub_tick_o    (sub_tick_o),
        .frame_start_o (frame_start_o)
    );

    assign rx_mclk_own_o = sel_q.mclk_own;
    assign rx_bclk_own_o = sel_q.bclk_own;
    assign div_mode_o    = sel_q.mode;
endmodule

// File: rtl/pcm_pwr_clk_ctrl_chk.sv
module pcm_pwr_clk_ctrl_chk #(
    parameter int TIMEOUT_CYC = 100000,
    localparam int IW = $clog2(TIMEOUT_CYC + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pwr_up,
    input logic          tx_en,
    input logic [1:0]    pd_cls,
    input logic [1:0]    bclk_cls,
    input logic          fs_any_rise,
    input logic [IW-1:0] idle,
    input logic          sub_tick,
    input logic          frame_start,
    input logic          rx_bclk_own
);
    localparam logic [IW-1:0] IDLE_LAST = IW'(TIMEOUT_CYC - 1);
    localparam logic [1:0]    CLS_HIGH  = 2'd1;
    localparam logic [1:0]    CLS_TOG   = 2'd2;

    a_r5_tx_needs_pwr: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en |-> pwr_up);

    a_r5_tx_after_wake: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> $past(pwr_up));

    a_r2_pd_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_cls == CLS_HIGH) |=> !pwr_up);

    a_r4_wake_needs_sync: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_up) |-> $past(fs_any_rise));

    a_r3_off_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_up) |-> ($past(pd_cls) == CLS_HIGH || $past(idle) == IDLE_LAST));

    a_r8_start_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> sub_tick);

    a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_up |=> !sub_tick);

    a_r7_static_shared: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk_cls != CLS_TOG) |=> !rx_bclk_own);
endmodule

bind pcm_pwr_clk_ctrl pcm_pwr_clk_ctrl_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_up      (pwr_up_o),
    .tx_en       (tx_out_en_o),
    .pd_cls      (pd_cls),
    .bclk_cls    (bclk_cls),
    .fs_any_rise (fs_any_rise),
    .idle        (fsm_idle),
    .sub_tick    (sub_tick_o),
    .frame_start (frame_start_o),
    .rx_bclk_own (rx_bclk_own_o)
);

// File: tb/pcm_pwr_clk_ctrl_tb_top.sv
`timescale 1ns/1ps
module pcm_pwr_clk_ctrl_tb_top;
    localparam int STATIC_CYC  = 8;
    localparam int TIMEOUT_CYC = 300;
    localparam int MCLK_PER    = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mclkx = 1'b0;
    logic fsx = 1'b0, fsr_t = 1'b0, fsr_ka = 1'b0;
    logic pd_lvl = 1'b0, pd_osc = 1'b0, pd_tog = 1'b0;
    logic bc_lvl = 1'b0, bc_osc = 1'b0, bc_tog = 1'b0;
    logic sel_193 = 1'b0;
    logic ka_en = 1'b0;
    logic fsr, mclkr_pd, bclkr_sel;

    logic       pwr_up, tx_en, mclk_own, bclk_own, sub_tick, frame_start;
    logic [1:0] div_mode;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    assign fsr       = fsr_t | fsr_ka;
    assign mclkr_pd  = pd_tog ? pd_osc : pd_lvl;
    assign bclkr_sel = bc_tog ? bc_osc : bc_lvl;

    always #5 clk = ~clk;

    pcm_pwr_clk_ctrl #(
        .STATIC_CYC     (STATIC_CYC),
        .TIMEOUT_CYC    (TIMEOUT_CYC),
        .DEFAULT_NARROW (1'b0)
    ) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .mclkx_i       (mclkx),
        .mclkr_pd_i    (mclkr_pd),
        .bclkr_sel_i   (bclkr_sel),
        .fsx_i         (fsx),
        .fsr_i         (fsr),
        .sel_193_i     (sel_193),
        .pwr_up_o      (pwr_up),
        .tx_out_en_o   (tx_en),
        .rx_mclk_own_o (mclk_own),
        .rx_bclk_own_o (bclk_own),
        .div_mode_o    (div_mode),
        .sub_tick_o    (sub_tick),
        .frame_start_o (frame_start)
    );

    // background stimulus
    initial forever begin
        repeat (MCLK_PER / 2) @(negedge clk);
        mclkx = ~mclkx;
    end
    initial forever begin
        repeat (3) @(negedge clk);
        pd_osc = ~pd_osc;
        bc_osc = ~bc_osc;
    end
    initial forever begin
        @(negedge clk);
        if (ka_en) begin
            fsr_ka = 1'b1;
            @(negedge clk);
            fsr_ka = 1'b0;
            repeat (148) @(negedge clk);
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_fsx();
        @(negedge clk) fsx = 1'b1;
        @(negedge clk) fsx = 1'b0;
    endtask

    task automatic pulse_fsr();
        @(negedge clk) fsr_t = 1'b1;
        @(negedge clk) fsr_t = 1'b0;
    endtask

    // measure two whole frames: cycles between frame starts and ticks within
    task automatic measure_frames(input int frame_len, input string tag);
        int guard = 0;
        @(negedge clk);
        while (!frame_start && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        check(frame_start == 1'b1, {tag, " frame start seen"}, int'(frame_start), 1);
        for (int f = 0; f < 2; f++) begin
            int cyc = 0;
            int ticks = 1;
            forever begin
                @(negedge clk);
                cyc++;
                if (frame_start || cyc > 4000) break;
                if (sub_tick) ticks++;
            end
            check(cyc == frame_len * MCLK_PER, {tag, " frame period"}, cyc, frame_len * MCLK_PER);
            check(ticks == 32, {tag, " ticks per frame"}, ticks, 32);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(2);
        // R1 reset state
        check(pwr_up == 0,   "R1 pwr_up",      pwr_up, 0);
        check(tx_en == 0,    "R1 tx_out_en",   tx_en, 0);
        check(mclk_own == 0, "R1 rx_mclk_own", mclk_own, 0);
        check(bclk_own == 0, "R1 rx_bclk_own", bclk_own, 0);
        check(div_mode == 0, "R1 div_mode",    div_mode, 0);
        check(sub_tick == 0 && frame_start == 0, "R1 divider quiet", int'(sub_tick), 0);

        // R2 static high power-down pin blocks wake-up
        pd_lvl = 1'b1;
        wait_cyc(20);
        pulse_fsx();
        pulse_fsr();
        wait_cyc(10);
        check(pwr_up == 0, "R2 syncs ignored while pin high", pwr_up, 0);
        check(tx_en == 0,  "R2 output off while pin high", tx_en, 0);

        // R4 wake on receive sync, R5 gating of the transmit output
        pd_lvl = 1'b0;
        wait_cyc(20);
        pulse_fsr();
        wait_cyc(6);
        check(pwr_up == 1, "R4 wake on receive sync", pwr_up, 1);
        check(tx_en == 0,  "R5 output off after wake", tx_en, 0);
        pulse_fsx();
        wait_cyc(6);
        check(tx_en == 0,  "R5 output off after first fsx", tx_en, 0);
        pulse_fsx();
        wait_cyc(6);
        check(tx_en == 1,  "R5 output on after second fsx", tx_en, 1);

        // R3 timeout
        wait_cyc(TIMEOUT_CYC - 40);
        check(pwr_up == 1, "R3 still up before timeout", pwr_up, 1);
        wait_cyc(60);
        check(pwr_up == 0, "R3 down after timeout", pwr_up, 0);
        check(tx_en == 0,  "R5 output off after timeout", tx_en, 0);

        // R2 pin high while powered
        pulse_fsx();
        wait_cyc(6);
        check(pwr_up == 1, "R4 wake on transmit sync", pwr_up, 1);
        pd_lvl = 1'b1;
        wait_cyc(20);
        check(pwr_up == 0, "R2 pin high powers down", pwr_up, 0);
        pd_lvl = 1'b0;
        wait_cyc(20);

        // R10 timeout versus new sync in the same cycle
        for (int d = TIMEOUT_CYC - 2; d <= TIMEOUT_CYC + 2; d++) begin
            pulse_fsx();
            wait_cyc(4);
            pulse_fsx();
            wait_cyc(d - 2);
            pulse_fsx();
            wait_cyc(6);
            check(pwr_up == 1, "R10 powered after spaced sync", pwr_up, 1);
            check(tx_en == (d <= TIMEOUT_CYC), "R10 gate kept iff spacing within timeout",
                  int'(tx_en), int'(d <= TIMEOUT_CYC));
            wait_cyc(TIMEOUT_CYC + 20);
        end

        // R6 / R9 power-down pin toggling
        pd_tog = 1'b1;
        wait_cyc(20);
        check(mclk_own == 1, "R6 receive master clock own when toggling", mclk_own, 1);
        pulse_fsr();
        wait_cyc(6);
        check(pwr_up == 1, "R4 wake with toggling pin", pwr_up, 1);
        @(negedge pd_osc);
        pd_tog = 1'b0;
        pd_lvl = 1'b0;
        wait_cyc(4);
        check(mclk_own == 1, "R9 still toggling shortly after last edge", mclk_own, 1);
        wait_cyc(STATIC_CYC + 2);
        check(mclk_own == 0, "R9 static after quiet window", mclk_own, 0);
        check(mclk_own == 0, "R6 transmit master clock used when static", mclk_own, 0);

        // R7 / R8 clock select and divider sweep
        ka_en = 1'b1;
        bc_lvl = 1'b0;
        wait_cyc(30);
        check(bclk_own == 0, "R7 shared bit clock when static low", bclk_own, 0);
        check(div_mode == 0, "R7 static low selects 2.048", div_mode, 0);
        measure_frames(256, "R8 2.048");

        bc_lvl = 1'b1;
        sel_193 = 1'b0;
        wait_cyc(30);
        check(bclk_own == 0, "R7 shared bit clock when static high", bclk_own, 0);
        check(div_mode == 1, "R7 static high selects 1.536", div_mode, 1);
        measure_frames(192, "R8 1.536");

        sel_193 = 1'b1;
        wait_cyc(30);
        check(div_mode == 2, "R7 static high with 193 selects 1.544", div_mode, 2);
        measure_frames(193, "R8 1.544");

        bc_tog = 1'b1;
        wait_cyc(30);
        check(bclk_own == 1, "R7 own bit clock when toggling", bclk_own, 1);
        check(div_mode == 0, "R7 toggling uses default mode", div_mode, 0);
        measure_frames(256, "R8 default");
        ka_en = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule